// File: doc/BRIEF.md
# Dirty Band Span Coalescer

The block walks the per-page dirty flags of a frame buffer and converts them into a short list of screen regions that need to be refreshed. Each flag stands for a band of four display lines. A scan runs through the bands in ascending order, one band per clock. Consecutive dirty bands are merged into a single full-width region, described by its first line and its height. While scanning, the block also records the lowest and the highest dirty page numbers, so that a later stage can clear all the flags with one range operation instead of one operation per page.

A scan starts with a one-cycle start pulse. The line count, the active width and the plane mode are captured at that pulse. The block reads flags through a simple combinational lookup: it drives a page number and gets back that page's indexed-plane flag together with eight flags from the two 32-bit planes. In mixed-depth mode any of those nine flags marks the band dirty. In indexed-only mode only the indexed-plane flag counts. The block does not redraw any pixels itself.

Top module: `dirty_span_coalescer`

## Requirements
- R1: A scan over L lines looks at pages 0 up to ceil(L/4)-1 in ascending order, one page per cycle, and drives page k on `lk_page` in the k-th cycle after the accepted start (cycle 0 is the first cycle after the start edge).
- R2: A run of dirty bands followed by a clean band produces exactly one region. Its `rgn_y` is 4 times the first dirty page and its `rgn_h` is 4 times the run length. `rgn_valid` is high for one cycle, in the cycle after the clean page was looked up.
- R3: A run that is still open when the scan reaches line L is emitted one cycle after the end-of-scan cycle (cycle ceil(L/4)+1). Its height reaches the end of its last band, so it is a multiple of 4 even when L is not.
- R4: Regions come out in strictly increasing line order. Each region carries `rgn_w` equal to the `active_width` captured at the accepted start.
- R5: In cycle ceil(L/4)+2, `clr_valid` pulses with `clr_lo` and `clr_hi` set to the lowest and highest dirty page numbers. If no band was dirty, `clr_valid` stays low.
- R6: When `mixed_mode` is 1 at start, a band is dirty if `lk_idx_dirty` is 1 or any bit of `lk_wide_dirty[7:0]` is 1. When it is 0, `lk_wide_dirty` has no effect.
- R7: `done` pulses for one cycle in cycle ceil(L/4)+3. `busy` is high from cycle 0 through cycle ceil(L/4)+2 and low otherwise.
- R8: A start pulse that arrives while `busy` is high is ignored. A change of `line_count` while busy does not change the running scan.
- R9: After reset, `rgn_valid`, `clr_valid`, `done` and `busy` are 0.
- R10: A scan with L = 0 emits no region and no clear range, and still pulses `done` in cycle 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a scan when idle |
| line_count | input | 11 | Number of display lines to cover (at most MAX_LINES) |
| active_width | input | 11 | Width reported with every region |
| mixed_mode | input | 1 | 1: the 32-bit plane flags also mark bands dirty |
| lk_page | output | 8 | Page number being looked up |
| lk_idx_dirty | input | 1 | Indexed-plane dirty flag of `lk_page` |
| lk_wide_dirty | input | 8 | Flags of the four matching pages in each of the two 32-bit planes |
| rgn_valid | output | 1 | One-cycle strobe for a merged region |
| rgn_y | output | 11 | First line of the region |
| rgn_h | output | 11 | Height of the region in lines |
| rgn_w | output | 11 | Width of the region |
| clr_valid | output | 1 | One-cycle strobe for the page range to clear |
| clr_lo | output | 8 | Lowest dirty page |
| clr_hi | output | 8 | Highest dirty page |
| done | output | 1 | One-cycle pulse that ends the scan |
| busy | output | 1 | A scan is in progress |

## Verification
Several dirty patterns are applied, and each one separates a different fault:
- Isolated and adjacent dirty pages separate merging from per-page emission.
- A run that touches the last band, with a line count that is not a multiple of four, exposes a missing or short end-of-scan flush.
- Flags set only in the 32-bit planes, scanned once in each mode, show whether the mode gate works.
- An all-dirty full frame and an empty zero-line frame probe the range limits and the no-clear case.
- A second start and a changed line count, applied during an alternating-pattern scan, show whether busy-time inputs leak into the result.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    // lines covered by one dirty flag, as a shift amount
    localparam int BAND_SHIFT = 2;
    localparam int BAND_LINES = 1 << BAND_SHIFT;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } dbc_state_e;

    function automatic logic band_is_dirty(input logic idx_flag,
                                           input logic any_wide,
                                           input logic mixed);
        return idx_flag | (mixed & any_wide);
    endfunction

endpackage

// File: rtl/dbc_band_eval.sv
module dbc_band_eval
    import dbc_pkg::*;
#(
    parameter int WIDE_BITS = 8
) (
    input  logic                 idx_flag,
    input  logic [WIDE_BITS-1:0] wide_flags,
    input  logic                 mixed,
    output logic                 dirty
);
    always_comb begin
        dirty = band_is_dirty(idx_flag, |wide_flags, mixed);
    end
endmodule

// File: rtl/dbc_span_tracker.sv
module dbc_span_tracker #(
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          begin_scan,
    input  logic          step,
    input  logic          dirty,
    input  logic          finish,
    input  logic [LW-1:0] cur_y,
    output logic          valid,
    output logic [LW-1:0] y_out,
    output logic [LW-1:0] h_out
);
    logic          open_q;
    logic [LW-1:0] ys_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            ys_q   <= '0;
            valid  <= 1'b0;
            y_out  <= '0;
            h_out  <= '0;
        end else begin
            valid <= 1'b0;
            if (begin_scan) begin
                open_q <= 1'b0;
            end else if (step) begin
                if (dirty) begin
                    if (!open_q) begin
                        open_q <= 1'b1;
                        ys_q   <= cur_y;
                    end
                end else if (open_q) begin
                    valid  <= 1'b1;
                    y_out  <= ys_q;
                    h_out  <= cur_y - ys_q;
                    open_q <= 1'b0;
                end
            end else if (finish && open_q) begin
                valid  <= 1'b1;
                y_out  <= ys_q;
                h_out  <= cur_y - ys_q;
                open_q <= 1'b0;
            end
        end
    end

    // checker state: end line of the previous region in this scan
    logic          have_prev_q;
    logic [LW-1:0] prev_end_q;
    always_ff @(posedge clk) begin
        if (rst || begin_scan) begin
            have_prev_q <= 1'b0;
            prev_end_q  <= '0;
        end else if (valid) begin
            have_prev_q <= 1'b1;
            prev_end_q  <= y_out + h_out;
        end
    end

    // R2: regions are band aligned and never empty
    p_band_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        valid |-> (y_out[1:0] == 2'b00 && h_out[1:0] == 2'b00 && h_out != '0));

    // R4: a new region starts past the end of the previous one
    p_ascending_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && have_prev_q) |-> (y_out > prev_end_q));

    // R2: regions never come out back to back
    p_gap_r2: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
endmodule

// File: rtl/dbc_range_tracker.sv
module dbc_range_tracker #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          begin_scan,
    input  logic          mark,
    input  logic [PW-1:0] page,
    output logic [PW-1:0] lo,
    output logic [PW-1:0] hi,
    output logic          any
);
    always_ff @(posedge clk) begin
        if (rst || begin_scan) begin
            lo  <= '1;
            hi  <= '0;
            any <= 1'b0;
        end else if (mark) begin
            if (!any || page < lo) lo <= page;
            if (!any || page > hi) hi <= page;
            any <= 1'b1;
        end
    end

    // R5: the recorded range is ordered once a page was dirty
    p_range_ordered_r5: assert property (@(posedge clk) disable iff (rst)
        any |-> (lo <= hi));
endmodule

// File: rtl/dirty_span_coalescer.sv
module dirty_span_coalescer
    import dbc_pkg::*;
#(
    parameter int MAX_LINES     = 1024,
    parameter int WIDTH_W       = 11,
    parameter int WIDE_PLANES   = 2,
    parameter int WIDE_PER_BAND = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   start,
    input  logic [$clog2(MAX_LINES+1)-1:0]         line_count,
    input  logic [WIDTH_W-1:0]                     active_width,
    input  logic                                   mixed_mode,
    output logic [$clog2((MAX_LINES+3)/4)-1:0]     lk_page,
    input  logic                                   lk_idx_dirty,
    input  logic [WIDE_PLANES*WIDE_PER_BAND-1:0]   lk_wide_dirty,
    output logic                                   rgn_valid,
    output logic [$clog2(MAX_LINES+1)-1:0]         rgn_y,
    output logic [$clog2(MAX_LINES+1)-1:0]         rgn_h,
    output logic [WIDTH_W-1:0]                     rgn_w,
    output logic                                   clr_valid,
    output logic [$clog2((MAX_LINES+3)/4)-1:0]     clr_lo,
    output logic [$clog2((MAX_LINES+3)/4)-1:0]     clr_hi,
    output logic                                   done,
    output logic                                   busy
);
    localparam int LW        = $clog2(MAX_LINES + 1);
    localparam int PAGES     = (MAX_LINES + BAND_LINES - 1) / BAND_LINES;
    localparam int PW        = $clog2(PAGES);
    localparam int CW        = LW;
    localparam int YW        = CW + BAND_SHIFT;
    localparam int WIDE_BITS = WIDE_PLANES * WIDE_PER_BAND;

    dbc_state_e         state_q;
    logic [CW-1:0]      cnt_q;
    logic [LW-1:0]      lines_q;
    logic [WIDTH_W-1:0] width_q;
    logic               mixed_q;
    logic               clr_q, done_q;

    logic          accept, at_end, step, band_dirty, any_dirty;
    logic [YW-1:0] cur_y;

    assign accept = (state_q == ST_IDLE) && start;
    assign cur_y  = {cnt_q, {BAND_SHIFT{1'b0}}};
    assign at_end = (state_q == ST_SCAN) && (cur_y >= {{BAND_SHIFT{1'b0}}, lines_q});
    assign step   = (state_q == ST_SCAN) && !at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lines_q <= '0;
            width_q <= '0;
            mixed_q <= 1'b0;
            clr_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            clr_q  <= 1'b0;
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_SCAN;
                    cnt_q   <= '0;
                    lines_q <= line_count;
                    width_q <= active_width;
                    mixed_q <= mixed_mode;
                end
                ST_SCAN: begin
                    if (at_end) state_q <= ST_FLUSH;
                    else        cnt_q   <= cnt_q + 1'b1;
                end
                ST_FLUSH: begin
                    clr_q   <= any_dirty;
                    state_q <= ST_DONE;
                end
                default: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    dbc_band_eval #(.WIDE_BITS(WIDE_BITS)) u_eval (
        .idx_flag   (lk_idx_dirty),
        .wide_flags (lk_wide_dirty),
        .mixed      (mixed_q),
        .dirty      (band_dirty)
    );

    dbc_span_tracker #(.LW(LW)) u_span (
        .clk        (clk),
        .rst        (rst),
        .begin_scan (accept),
        .step       (step),
        .dirty      (band_dirty),
        .finish     (at_end),
        .cur_y      (cur_y[LW-1:0]),
        .valid      (rgn_valid),
        .y_out      (rgn_y),
        .h_out      (rgn_h)
    );

    dbc_range_tracker #(.PW(PW)) u_range (
        .clk        (clk),
        .rst        (rst),
        .begin_scan (accept),
        .mark       (step && band_dirty),
        .page       (cnt_q[PW-1:0]),
        .lo         (clr_lo),
        .hi         (clr_hi),
        .any        (any_dirty)
    );

    assign lk_page   = cnt_q[PW-1:0];
    assign rgn_w     = width_q;
    assign clr_valid = clr_q;
    assign done      = done_q;
    assign busy      = (state_q != ST_IDLE);

    // R8: captured scan settings hold while a scan runs, whatever arrives
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> ($stable(lines_q) && $stable(width_q) && $stable(mixed_q)));

    // R7: the clear slot is followed directly by the done pulse
    p_done_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |=> (done && !busy));

    // R9: no region leaves the block outside a scan
    p_region_in_scan_r9: assert property (@(posedge clk) disable iff (rst)
        rgn_valid |-> busy);

    // R1: the page counter only advances by one while scanning
    p_page_step_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && !at_end) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R1: the line count never exceeds the supported frame height
    p_lines_range_r1: assert property (@(posedge clk) disable iff (rst)
        accept |-> (int'(line_count) <= MAX_LINES));
endmodule

// File: tb/dirty_span_coalescer_tb.sv
`timescale 1ns/100ps
module dirty_span_coalescer_tb_top;
    localparam int MAX_LINES = 1024;
    localparam int PAGES     = MAX_LINES / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [10:0] line_count = '0;
    logic [10:0] active_width = '0;
    logic        mixed_mode = 1'b0;
    logic [7:0]  lk_page;
    logic        lk_idx_dirty;
    logic [7:0]  lk_wide_dirty;
    logic        rgn_valid, clr_valid, done, busy;
    logic [10:0] rgn_y, rgn_h, rgn_w;
    logic [7:0]  clr_lo, clr_hi;

    logic       idx_mem  [PAGES];
    logic [7:0] wide_mem [PAGES];

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign lk_idx_dirty  = idx_mem[lk_page];
    assign lk_wide_dirty = wide_mem[lk_page];

    dirty_span_coalescer dut_i (
        .clk(clk), .rst(rst), .start(start), .line_count(line_count),
        .active_width(active_width), .mixed_mode(mixed_mode),
        .lk_page(lk_page), .lk_idx_dirty(lk_idx_dirty), .lk_wide_dirty(lk_wide_dirty),
        .rgn_valid(rgn_valid), .rgn_y(rgn_y), .rgn_h(rgn_h), .rgn_w(rgn_w),
        .clr_valid(clr_valid), .clr_lo(clr_lo), .clr_hi(clr_hi),
        .done(done), .busy(busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wipe();
        for (int i = 0; i < PAGES; i++) begin
            idx_mem[i]  = 1'b0;
            wide_mem[i] = 8'h00;
        end
    endtask

    // behavioural reference: expected events keyed by cycle after the start edge
    task automatic run_scan(input int lines, input bit mixed, input int width,
                            input bit poke, input string tag);
        int ecyc[$];
        int ey[$];
        int eh[$];
        int y = 0, k = 0, ys = 0, lo = 1 << 30, hi = -1;
        bit open = 0;
        bit d;
        int n;
        while (y < lines) begin
            d = idx_mem[k] || (mixed && wide_mem[k] != 8'h00);
            if (d) begin
                if (!open) begin open = 1; ys = y; end
                if (k < lo) lo = k;
                if (k > hi) hi = k;
            end else if (open) begin
                ecyc.push_back(k + 1); ey.push_back(ys); eh.push_back(y - ys);
                open = 0;
            end
            y += 4;
            k++;
        end
        if (open) begin
            ecyc.push_back(k + 1); ey.push_back(ys); eh.push_back(y - ys);
        end
        n = k;

        line_count   = 11'(lines);
        mixed_mode   = mixed;
        active_width = 11'(width);
        start        = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int c = 0; c <= n + 4; c++) begin
            bit exp_rv;
            exp_rv = (ecyc.size() > 0) && (ecyc[0] == c);
            if (c < n) chk("R1", {tag, " lk_page"}, int'(lk_page), c);
            chk(ecyc.size() > 0 && ecyc[0] == n + 1 ? "R3" : "R2",
                {tag, " rgn_valid"}, int'(rgn_valid), int'(exp_rv));
            if (exp_rv && rgn_valid) begin
                chk("R2", {tag, " rgn_y"}, int'(rgn_y), ey[0]);
                chk("R2", {tag, " rgn_h"}, int'(rgn_h), eh[0]);
                chk("R4", {tag, " rgn_w"}, int'(rgn_w), width);
            end
            if (exp_rv) begin
                void'(ecyc.pop_front()); void'(ey.pop_front()); void'(eh.pop_front());
            end
            chk("R5", {tag, " clr_valid"}, int'(clr_valid), int'(c == n + 2 && hi >= 0));
            if (c == n + 2 && hi >= 0) begin
                chk("R5", {tag, " clr_lo"}, int'(clr_lo), lo);
                chk("R5", {tag, " clr_hi"}, int'(clr_hi), hi);
            end
            chk(lines == 0 ? "R10" : "R7", {tag, " done"}, int'(done), int'(c == n + 3));
            chk("R7", {tag, " busy"}, int'(busy), int'(c <= n + 2));
            if (poke && c == 1) begin
                start = 1'b1;
                line_count = 11'(lines + 12);
            end
            if (poke && c == 2) start = 1'b0;
            @(posedge clk); #1;
        end
        chk("R4", {tag, " leftover regions"}, ecyc.size(), 0);
    endtask

    initial begin
        wipe();
        repeat (3) @(posedge clk);
        #1;
        // R9: idle outputs straight after reset
        chk("R9", "rgn_valid", int'(rgn_valid), 0);
        chk("R9", "clr_valid", int'(clr_valid), 0);
        chk("R9", "done", int'(done), 0);
        chk("R9", "busy", int'(busy), 0);
        rst = 1'b0;
        @(posedge clk); #1;

        // R2: isolated and adjacent dirty pages
        wipe();
        idx_mem[1] = 1; idx_mem[2] = 1; idx_mem[5] = 1;
        run_scan(32, 1'b0, 640, 1'b0, "basic");

        // R3: run at frame start and a run reaching a ragged frame end
        wipe();
        idx_mem[0] = 1; idx_mem[6] = 1; idx_mem[7] = 1;
        run_scan(30, 1'b0, 800, 1'b0, "tail");

        // R6: 32-bit plane flags only; plain mode must ignore them
        wipe();
        wide_mem[3] = 8'h40; wide_mem[4] = 8'h02;
        run_scan(24, 1'b0, 320, 1'b0, "plain");
        run_scan(24, 1'b1, 321, 1'b0, "mixed");

        // R10: empty frame
        wipe();
        idx_mem[0] = 1;
        run_scan(0, 1'b0, 100, 1'b0, "zero");

        // R3/R5: full frame, everything dirty
        for (int i = 0; i < PAGES; i++) idx_mem[i] = 1;
        run_scan(MAX_LINES, 1'b0, 1024, 1'b0, "full");

        // R8: alternating pattern with a start and line change while busy
        wipe();
        for (int i = 0; i < 10; i += 2) idx_mem[i] = 1;
        run_scan(40, 1'b0, 512, 1'b1, "poke");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule